// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters written by a processor into a serial bit stream. A character written over the write port lands in a holding register. As soon as the output shift register is free and the clear-to-send input permits, the character moves into the shifter on its own. The holding register is then free again, so software can queue the next character while the current one is still on the line. Two flags report progress. The ready flag says that the holding register can take a character. The empty flag says that no data character is queued or being sent.

Bit timing comes from a transmit tick input that is qualified by the system clock. In asynchronous framing, each bit lasts 1, 16 or 64 ticks. Each character is framed by a start bit, an optional parity bit and one or two stop bits. In synchronous framing there is no start or stop bit and each bit lasts one tick. When no data is queued, the shifter sends a programmable sync character, so the line never runs dry.

Top module: `dbl_serial_tx`

## Requirements
- R1: After reset, txRdy is 1, txEmpty is 1 and txd is 1.
- R2: In asynchronous mode (cfgSync=0) a character is sent as a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits at 1. The number of data bits is 5 + cfgLen: cfgLen 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: With cfgParEn=1 a parity bit follows the data. With cfgParOdd=0 the data bits and the parity bit together hold an even number of ones; with cfgParOdd=1 they hold an odd number.
- R4: In asynchronous mode each bit lasts as many txTick pulses as cfgFactor selects: 00 gives 1, 01 gives 16, 10 or 11 gives 64. In synchronous mode each bit lasts one txTick pulse.
- R5: txRdy is low in the cycle after an accepted write. It rises when the held character moves into the shifter. A second character written while the first is shifting is sent after the first one.
- R6: A write (cpuWr) while txRdy is low is ignored. The held character and the sent stream are unchanged.
- R7: While ctsN is high, no new character starts and txd stays 1 between characters. A character that is already shifting completes.
- R8: txEmpty is low in the cycle after an accepted write. It is high again once the holding register is empty and no data character is being shifted.
- R9: In synchronous mode (cfgSync=1) characters carry no start or stop bit. Whenever the shifter is free, ctsN is low and nothing is held, the sync character is sent. During that fill txEmpty stays high.
- R10: The sync character register loads cpuData when syncWr is high, and it resets to 0x16.
- R11: In asynchronous mode, whenever txEmpty is high the line txd is 1.
- R12: With stop2=1 an asynchronous character ends with two stop bits instead of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWr | input | 1 | Write strobe for a data character |
| syncWr | input | 1 | Write strobe for the sync character register |
| cpuData | input | 8 | Write data for both strobes |
| cfgSync | input | 1 | 1 selects synchronous framing |
| cfgLen | input | 2 | Data bits per character minus 5 |
| cfgParEn | input | 1 | Parity bit enable |
| cfgParOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfgStop2 | input | 1 | Two stop bits in asynchronous mode |
| cfgFactor | input | 2 | Ticks per bit: 00 gives 1, 01 gives 16, 1x gives 64 |
| ctsN | input | 1 | Clear to send, active low |
| txTick | input | 1 | Transmit clock enable, one pulse per tick |
| txd | output | 1 | Serial line |
| txRdy | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | No data character held or shifting |

## Verification
The hardest case to reach from the ports is a write that arrives while the holding register is already full. It can only happen while an earlier character occupies the shifter. The stimulus therefore queues a second character right behind the first and writes a third one before the shifter frees up. The received stream must then hold exactly the first two characters.

Bringing the synchronous stream back into frame after a clear-to-send pause is also delicate. The serial monitor re-aligns on the clock edge where clear-to-send is seen low again. A character written during the pause must come out first, and fill characters carrying the new sync value must follow it.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic       syncMode;
    logic [1:0] charLen;
    logic       parEn;
    logic       parOdd;
  } txFmt_t;

  typedef struct packed {
    logic takeCpu;
    logic loadData;
    logic loadSync;
    logic shift;
    logic idle;
  } txStrobe_t;

  // number of line bits a character occupies
  function automatic logic [CNT_W-1:0] frameBits(logic syncMode, logic [1:0] charLen,
                                                 logic parEn, logic stop2);
    int n;
    n = 5 + int'(charLen) + (parEn ? 1 : 0);
    if (!syncMode) n = n + 2 + (stop2 ? 1 : 0);
    return CNT_W'(n);
  endfunction

  // line bits, bit 0 sent first; unused upper bits stay 1 (stop/idle)
  function automatic logic [FRAME_W-1:0] buildFrame(logic [DATA_W-1:0] d, txFmt_t f);
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   pos;
    logic               par;
    int                 n;
    bits = '1;
    pos  = '0;
    n    = 5 + int'(f.charLen);
    par  = f.parOdd;
    if (!f.syncMode) begin
      bits[0] = 1'b0;
      pos     = CNT_W'(1);
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (i < n) begin
        bits[pos] = d[i];
        par       = par ^ d[i];
        pos       = pos + CNT_W'(1);
      end
    end
    if (f.parEn) bits[pos] = par;
    return bits;
  endfunction
endpackage

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import tx_pkg::*;
#(
  parameter int FACT_MID = 16,
  parameter int FACT_HI  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWr,
  input  logic             ctsN,
  input  logic             txTick,
  input  logic             syncMode,
  input  logic [1:0]       factor,
  input  logic [CNT_W-1:0] frameLen,
  output txStrobe_t        stb,
  output logic             txRdy,
  output logic             txEmpty
);
  localparam int DIV_W = $clog2(FACT_HI);

  logic             bufFull, busy, dataMode;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] tickCnt, divLim;
  logic             bitDone, lastBit, frameEnd, canStart;
  logic             takeCpu, loadData, loadSync, shiftNext, goIdle;

  always_comb begin
    if (syncMode || factor == 2'b00) divLim = '0;
    else if (factor == 2'b01)        divLim = DIV_W'(FACT_MID - 1);
    else                             divLim = DIV_W'(FACT_HI - 1);
  end

  assign bitDone  = busy && txTick && (tickCnt == divLim);
  assign lastBit  = (bitCnt == '0);
  assign frameEnd = bitDone && lastBit;
  assign canStart = (!busy || frameEnd) && !ctsN;

  assign takeCpu   = cpuWr && !bufFull;
  assign loadData  = canStart && bufFull;
  assign loadSync  = canStart && !bufFull && syncMode;
  assign shiftNext = bitDone && !lastBit;
  assign goIdle    = frameEnd && !loadData && !loadSync;

  always_comb begin
    stb          = '0;
    stb.takeCpu  = takeCpu;
    stb.loadData = loadData;
    stb.loadSync = loadSync;
    stb.shift    = shiftNext;
    stb.idle     = goIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull  <= 1'b0;
      busy     <= 1'b0;
      dataMode <= 1'b0;
      bitCnt   <= '0;
      tickCnt  <= '0;
    end else begin
      if (takeCpu)       bufFull <= 1'b1;
      else if (loadData) bufFull <= 1'b0;

      if (loadData || loadSync) begin
        busy     <= 1'b1;
        dataMode <= loadData;
        bitCnt   <= frameLen - CNT_W'(1);
        tickCnt  <= '0;
      end else if (shiftNext) begin
        bitCnt  <= bitCnt - CNT_W'(1);
        tickCnt <= '0;
      end else if (goIdle) begin
        busy     <= 1'b0;
        dataMode <= 1'b0;
        tickCnt  <= '0;
      end else if (busy && txTick) begin
        tickCnt <= tickCnt + DIV_W'(1);
      end
    end
  end

  assign txRdy   = !bufFull;
  assign txEmpty = !bufFull && !dataMode;
endmodule

// File: rtl/tx_dpath.sv
module tx_dpath
  import tx_pkg::*;
#(
  parameter logic [DATA_W-1:0] SYNC_INIT = 8'h16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  txFmt_t            fmt,
  input  logic              syncWr,
  input  logic [DATA_W-1:0] cpuData,
  output logic              txd
);
  logic [DATA_W-1:0]  holdReg, syncReg;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      syncReg <= SYNC_INIT;
      frame   <= '1;
    end else begin
      if (stb.takeCpu) holdReg <= cpuData;
      if (syncWr)      syncReg <= cpuData;
      if (stb.loadData)      frame <= buildFrame(holdReg, fmt);
      else if (stb.loadSync) frame <= buildFrame(syncReg, fmt);
      else if (stb.shift)    frame <= {1'b1, frame[FRAME_W-1:1]};
      else if (stb.idle)     frame <= '1;
    end
  end

  assign txd = frame[0];
endmodule

// File: rtl/dbl_serial_tx.sv
module dbl_serial_tx
  import tx_pkg::*;
#(
  parameter int                FACT_MID  = 16,
  parameter int                FACT_HI   = 64,
  parameter logic [DATA_W-1:0] SYNC_INIT = 8'h16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic              syncWr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cfgSync,
  input  logic [1:0]        cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgStop2,
  input  logic [1:0]        cfgFactor,
  input  logic              ctsN,
  input  logic              txTick,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);
  txStrobe_t        stb;
  txFmt_t           fmt;
  logic [CNT_W-1:0] frameLen;

  assign fmt      = '{syncMode: cfgSync, charLen: cfgLen, parEn: cfgParEn, parOdd: cfgParOdd};
  assign frameLen = frameBits(cfgSync, cfgLen, cfgParEn, cfgStop2);

  tx_ctrl #(.FACT_MID(FACT_MID), .FACT_HI(FACT_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .ctsN(ctsN), .txTick(txTick),
    .syncMode(cfgSync), .factor(cfgFactor), .frameLen(frameLen),
    .stb(stb), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  tx_dpath #(.SYNC_INIT(SYNC_INIT)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .fmt(fmt), .syncWr(syncWr),
    .cpuData(cpuData), .txd(txd)
  );
endmodule

// File: rtl/dbl_serial_tx_chk.sv
module dbl_serial_tx_chk (
  input logic clk,
  input logic rstN,
  input logic cpuWr,
  input logic cfgSync,
  input logic ctsN,
  input logic txd,
  input logic txRdy,
  input logic txEmpty
);
  // R5
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr && txRdy |=> !txRdy);

  // R8
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr && txRdy |=> !txEmpty);

  // R5
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRdy) |-> !txEmpty);

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSync && txEmpty |-> txd);

  // R7
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSync && ctsN && txEmpty |=> txd);
endmodule

bind dbl_serial_tx dbl_serial_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cfgSync(cfgSync), .ctsN(ctsN),
  .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
);

// File: tb/sim_dbl_serial_tx.sv
module sim_dbl_serial_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rstN = 1'b0, cpuWr = 1'b0, syncWr = 1'b0;
  logic [7:0] cpuData = 8'h00;
  logic       cfgSync = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgStop2 = 1'b0;
  logic [1:0] cfgLen = 2'b11, cfgFactor = 2'b00;
  logic       ctsN = 1'b0, txTick = 1'b0;
  logic       txd, txRdy, txEmpty;

  int total = 0, bad = 0;
  logic [7:0] expQ[$];
  int frames = 0, syncSeen = 0, tickPhase = 0;
  bit asyncMonOn = 0, syncMonOn = 0;
  logic [7:0] syncVal = 8'h16;

  int monState = 0, monT = 0;
  logic [7:0] monData = 8'h00, syncAcc = 8'h00;
  logic monPar = 1'b0;
  int syncK = 0;

  dbl_serial_tx u0 (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .syncWr(syncWr), .cpuData(cpuData),
    .cfgSync(cfgSync), .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgStop2(cfgStop2), .cfgFactor(cfgFactor), .ctsN(ctsN), .txTick(txTick),
    .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nBits();
    return 5 + int'(cfgLen);
  endfunction

  function automatic int fact();
    if (cfgFactor == 2'b00) return 1;
    if (cfgFactor == 2'b01) return 16;
    return 64;
  endfunction

  function automatic logic [7:0] maskData(logic [7:0] d);
    return d & ((8'd1 << nBits()) - 8'd1);
  endfunction

  task automatic finishFrame();
    logic [7:0] e;
    if (expQ.size() == 0) begin
      chk(0, "R6", "unexpected frame", int'(monData), 0);
    end else begin
      e = expQ.pop_front();
      chk(monData == e, "R2", "frame data", int'(monData), int'(e));
      if (cfgParEn) chk(monPar == ((^e) ^ cfgParOdd), "R3", "parity bit", int'(monPar), int'((^e) ^ cfgParOdd));
    end
    frames++;
  endtask

  // tick generator plus serial monitors (one process, so tick and sample agree)
  always @(negedge clk) begin
    tickPhase++;
    txTick = (tickPhase % 4) != 0;
    if (txTick && asyncMonOn) begin
      if (monState == 0) begin
        if (txd == 1'b0) begin
          monState = 1; monT = 0; monData = 8'h00;
        end
      end else begin
        monT++;
        if (monT % fact() == 0) begin
          int b;
          int p;
          b = monT / fact();
          p = cfgParEn ? 1 : 0;
          if (b <= nBits()) monData[b-1] = txd;
          else if (p == 1 && b == nBits() + 1) monPar = txd;
          else begin
            chk(txd == 1'b1, "R12", "stop bit", int'(txd), 1);
            if (b - nBits() - p == (cfgStop2 ? 2 : 1)) begin
              finishFrame();
              monState = 0;
            end
          end
        end
      end
    end
    if (txTick && syncMonOn) begin
      syncAcc[syncK] = txd;
      syncK++;
      if (syncK == 8) begin
        syncK = 0;
        if (syncAcc == syncVal) syncSeen++;
        else if (expQ.size() > 0 && expQ[0] == syncAcc) begin
          void'(expQ.pop_front());
          frames++;
          chk(1, "R9", "data in sync stream", int'(syncAcc), int'(syncAcc));
        end else chk(0, "R9", "sync stream chunk", int'(syncAcc), int'(syncVal));
      end
    end
  end

  task automatic cpuWrite(logic [7:0] d);
    @(negedge clk);
    if (txRdy) expQ.push_back(maskData(d));
    cpuWr = 1'b1; cpuData = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic waitIdle(string req);
    bit done;
    done = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (txEmpty && expQ.size() == 0 && monState == 0) begin
        done = 1;
        break;
      end
    end
    chk(done, req, "drain to idle", int'(expQ.size()), 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int n0;
    bit stayedHigh;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txRdy == 1'b1, "R1", "txRdy after reset", int'(txRdy), 1);
    chk(txEmpty == 1'b1, "R1", "txEmpty after reset", int'(txEmpty), 1);
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    asyncMonOn = 1;

    // 8 bits, no parity, 1 stop, 1x: queue behind a shifting char, then a dropped write
    cpuWrite(8'hA5);
    chk(txRdy == 1'b0, "R5", "txRdy after write", int'(txRdy), 0);
    chk(txEmpty == 1'b0, "R8", "txEmpty after write", int'(txEmpty), 0);
    @(negedge clk);
    chk(txRdy == 1'b1, "R5", "txRdy after move to shifter", int'(txRdy), 1);
    chk(txEmpty == 1'b0, "R8", "txEmpty while shifting", int'(txEmpty), 0);
    cpuWrite(8'h3C);
    chk(txRdy == 1'b0, "R5", "txRdy with buffer held", int'(txRdy), 0);
    cpuWrite(8'hFF);  // R6: txRdy low, must be dropped
    waitIdle("R6");
    chk(frames == 2, "R6", "frames after dropped write", frames, 2);
    chk(txd == 1'b1, "R11", "line idle", int'(txd), 1);

    // 7 bits, even parity, 2 stops, 16x
    cfgLen = 2'b10; cfgParEn = 1'b1; cfgParOdd = 1'b0; cfgStop2 = 1'b1; cfgFactor = 2'b01;
    cpuWrite(8'h55);
    cpuWrite(8'h81);
    waitIdle("R4");
    chk(frames == 4, "R4", "frames at 16x", frames, 4);

    // 5 bits, odd parity, 1 stop, 64x
    cfgLen = 2'b00; cfgParOdd = 1'b1; cfgStop2 = 1'b0; cfgFactor = 2'b10;
    cpuWrite(8'h13);
    cpuWrite(8'h0E);
    waitIdle("R3");
    chk(frames == 6, "R3", "frames at 64x", frames, 6);

    // 6 bits, no parity, 16x: clear-to-send held off
    cfgLen = 2'b01; cfgParEn = 1'b0; cfgFactor = 2'b01;
    ctsN = 1'b1;
    cpuWrite(8'h2A);
    stayedHigh = 1;
    repeat (300) begin
      @(negedge clk);
      if (txd != 1'b1) stayedHigh = 0;
    end
    chk(stayedHigh, "R7", "line held while ctsN high", int'(stayedHigh), 1);
    chk(txRdy == 1'b0, "R7", "character still held", int'(txRdy), 0);
    ctsN = 1'b0;
    waitIdle("R7");
    chk(frames == 7, "R7", "frame after ctsN low", frames, 7);
    // ctsN rises mid-character: it completes
    cpuWrite(8'h15);
    repeat (40) @(negedge clk);
    ctsN = 1'b1;
    waitIdle("R7");
    chk(frames == 8, "R7", "frame completes under ctsN high", frames, 8);
    ctsN = 1'b0;

    // synchronous mode
    asyncMonOn = 0;
    @(negedge clk);
    rstN = 1'b0; ctsN = 1'b1;
    cfgSync = 1'b1; cfgLen = 2'b11; cfgParEn = 1'b0; cfgFactor = 2'b00;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd == 1'b1 && txEmpty == 1'b1, "R9", "no fill while ctsN high", int'({txd, txEmpty}), 3);
    ctsN = 1'b0;
    @(posedge clk); #1;
    syncK = 0; syncMonOn = 1;
    repeat (60) @(negedge clk);
    chk(syncSeen >= 3, "R10", "fill with reset sync value", syncSeen, 3);
    chk(txEmpty == 1'b1, "R9", "txEmpty during fill", int'(txEmpty), 1);
    syncMonOn = 0; ctsN = 1'b1;
    repeat (30) @(negedge clk);
    syncWr = 1'b1; cpuData = 8'h7E;
    @(negedge clk);
    syncWr = 1'b0;
    syncVal = 8'h7E; syncSeen = 0;
    n0 = frames;
    cpuWrite(8'hC3);
    chk(txEmpty == 1'b0, "R8", "txEmpty with data held", int'(txEmpty), 0);
    @(negedge clk);
    ctsN = 1'b0;
    @(posedge clk); #1;
    syncK = 0; syncMonOn = 1;
    repeat (20) @(negedge clk);
    cpuWrite(8'h0F);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (expQ.size() == 0) break;
    end
    repeat (40) @(negedge clk);
    chk(frames == n0 + 2, "R9", "data chars in sync stream", frames - n0, 2);
    chk(syncSeen >= 1, "R10", "fill with new sync value", syncSeen, 1);
    chk(txEmpty == 1'b1, "R9", "txEmpty after data sent", int'(txEmpty), 1);

    summary();
    $finish;
  end
endmodule